// File: doc/BRIEF.md
# Capacitive-Mode Guard Dead-Time Sequencer

This block sits between the frequency generator and the gate drivers of a half-bridge resonant converter. It decides when the next gate may turn on after the present one has turned off. It tracks which gate is currently permitted. When that gate's command falls, it samples the synchronized resonant-current polarity and judges whether the stage has slipped into capacitive (zero-current-switching) operation. The outcome is held in a flag, and each detection sends a one-cycle soft-start request so that the frequency generator ramps the switching frequency upward.

After each turn-off the block opens a dead interval in which neither gate is permitted. In normal operation the interval ends on a slew-done pulse or on a short timeout. With the capacitive flag set, a flip of the current polarity relative to the value sampled at the turn-off also ends the interval, and the timeout is stretched to a long limit. That limit defaults to 150 µs and is converted to clock cycles from a clock-frequency parameter. Detection is blocked while the light-load (burst) input is high, because the current is then too small for its polarity to be trusted.

Top module: `cmg_deadtime_seq`

## Requirements
- R1: After reset the high-side permission `hs_en` is 1, `ls_en` is 0, `zcs_flag` is 0 and `ss_req` is 0.
- R2: `hs_en` and `ls_en` are never 1 together. A falling edge counts only on the command of the gate that is currently permitted, and it hands permission only to the opposite gate. A command pulse on the non-permitted gate changes nothing.
- R3: At a counted falling edge of `hs_cmd`, with `light_load` at 0, `zcs_flag` becomes 1 if the synchronized `cur_pos` is 0 (negative current) and 0 if it is 1.
- R4: At a counted falling edge of `ls_cmd`, with `light_load` at 0, `zcs_flag` becomes 1 if the synchronized `cur_pos` is 1 (positive current) and 0 if it is 0.
- R5: If `light_load` is 1 at a counted falling edge, `zcs_flag` becomes 0 and no `ss_req` pulse is produced.
- R6: `zcs_flag` keeps its value through the dead interval and the following on-phase until the next counted falling edge.
- R7: `ss_req` is a single-cycle pulse in the cycle after a counted falling edge that sets `zcs_flag`, and it is 0 otherwise.
- R8: A one-cycle `slew_done` pulse during the dead interval ends it at the next clock edge, whatever the state of `zcs_flag`.
- R9: With `zcs_flag` at 1, a change of `cur_pos` away from the value sampled at the falling edge ends the dead interval once it has passed the SYNC_STAGES-flop synchronizer, which is 3 clocks after the change with the default of 2 stages. With `zcs_flag` at 0 such a change has no effect.
- R10: Without any other release event the dead interval lasts exactly NORM_CYC clocks when `zcs_flag` is 0 and ZCS_CYC clocks when it is 1. NORM_CYC is CLK_HZ/1000·NORM_DT_NS/10^6 and ZCS_CYC is CLK_HZ/10^6·ZCS_DT_US.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hs_cmd | input | 1 | High-side gate command from the frequency generator |
| ls_cmd | input | 1 | Low-side gate command from the frequency generator |
| cur_pos | input | 1 | Resonant-current polarity, 1 = positive, asynchronous |
| slew_done | input | 1 | Switch-node slew finished pulse, synchronous |
| light_load | input | 1 | Burst / light-load condition, blocks detection |
| hs_en | output | 1 | High-side gate permitted |
| ls_en | output | 1 | Low-side gate permitted |
| zcs_flag | output | 1 | Capacitive operation detected at last turn-off |
| ss_req | output | 1 | One-cycle soft-start request |

## Verification
The bench sweeps both gate sides, both polarities, both light-load levels and three release causes (none, slew-done, polarity flip), and counts the exact length of each dead interval. A design that swapped the polarity rule between the sides would raise the flag on inductive edges. One that ignored light load would send spurious soft-start requests. A flip honoured outside capacitive mode would cut the normal dead time from 10 clocks to 5. A timeout that picked the wrong limit, or that was off by one, shows up as a wrong interval count. A gate command on the non-permitted side is also pulsed, to catch a sequencer that reacts to either edge.

// File: rtl/cmg_pkg.sv
package cmg_pkg;
   typedef enum logic [1:0] {
      ST_HS_ON = 2'd0,
      ST_DT_LS = 2'd1,
      ST_LS_ON = 2'd2,
      ST_DT_HS = 2'd3
   } cmg_state_t;
endpackage

// File: rtl/cmg_pol_sync.sv
module cmg_pol_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);
   logic [SYNC_STAGES-1:0] stg;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_depth
         $error("cmg_pol_sync: SYNC_STAGES must be at least 2");
      end
      for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (!rst_n) stg[0] <= 1'b0;
               else        stg[0] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (!rst_n) stg[i] <= 1'b0;
               else        stg[i] <= stg[i-1];
            end
         end
      end
   endgenerate

   assign dout = stg[SYNC_STAGES-1];
endmodule

// File: rtl/cmg_zcs_detect.sv
module cmg_zcs_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic pol_s,
   input  logic fall_evt,
   input  logic fall_hs,
   input  logic light_load,
   output logic zcs_flag,
   output logic ss_req,
   output logic flip
);
   logic ref_pol;
   logic cap_now;

   // capacitive: negative current at high-side turn-off, positive at low-side
   assign cap_now = !light_load && (fall_hs ? !pol_s : pol_s);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         zcs_flag <= 1'b0;
         ss_req   <= 1'b0;
         ref_pol  <= 1'b0;
      end else if (fall_evt) begin
         zcs_flag <= cap_now;
         ss_req   <= cap_now;
         ref_pol  <= pol_s;
      end else begin
         ss_req   <= 1'b0;
      end
   end

   assign flip = (pol_s != ref_pol);

   // R6
   zcs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_evt |=> $stable(zcs_flag));
   // R5
   light_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_evt && light_load) |=> (!zcs_flag && !ss_req));
   // R7
   ss_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ss_req |-> (zcs_flag && $past(fall_evt)));
endmodule

// File: rtl/cmg_dt_timer.sv
module cmg_dt_timer #(
   parameter int NORM_CYC = 100,
   parameter int ZCS_CYC  = 15000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic run,
   input  logic long_sel,
   output logic expired
);
   localparam int CW = $clog2(ZCS_CYC + 1);
   localparam logic [CW-1:0] NORM_LAST = CW'(NORM_CYC - 1);
   localparam logic [CW-1:0] ZCS_LAST  = CW'(ZCS_CYC - 1);

   generate
      if (NORM_CYC < 1) begin : g_bad_norm
         $error("cmg_dt_timer: NORM_CYC must be at least 1");
      end
      if (ZCS_CYC <= NORM_CYC) begin : g_bad_zcs
         $error("cmg_dt_timer: ZCS_CYC must exceed NORM_CYC");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)     cnt <= '0;
      else if (start) cnt <= '0;
      else if (run)   cnt <= cnt + CW'(1);
   end

   assign expired = long_sel ? (cnt == ZCS_LAST) : (cnt == NORM_LAST);

   // R10
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= ZCS_LAST);
endmodule

// File: rtl/cmg_deadtime_seq.sv
module cmg_deadtime_seq #(
   parameter int CLK_HZ      = 100_000_000,
   parameter int NORM_DT_NS  = 1000,
   parameter int ZCS_DT_US   = 150,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_cmd,
   input  logic ls_cmd,
   input  logic cur_pos,
   input  logic slew_done,
   input  logic light_load,
   output logic hs_en,
   output logic ls_en,
   output logic zcs_flag,
   output logic ss_req
);
   import cmg_pkg::*;

   localparam int NORM_CYC = (CLK_HZ / 1000) * NORM_DT_NS / 1_000_000;
   localparam int ZCS_CYC  = (CLK_HZ / 1_000_000) * ZCS_DT_US;

   generate
      if (CLK_HZ < 1_000_000) begin : g_bad_clk
         $error("cmg_deadtime_seq: CLK_HZ must be at least 1 MHz");
      end
   endgenerate

   cmg_state_t state;
   logic hs_q, ls_q;
   logic hs_fall, ls_fall;
   logic fall_evt, fall_hs;
   logic dead, release_now, expired, flip, pol_s;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hs_q <= 1'b0;
         ls_q <= 1'b0;
      end else begin
         hs_q <= hs_cmd;
         ls_q <= ls_cmd;
      end
   end

   assign hs_fall  = hs_q && !hs_cmd;
   assign ls_fall  = ls_q && !ls_cmd;
   assign fall_hs  = (state == ST_HS_ON);
   assign fall_evt = (fall_hs && hs_fall) || ((state == ST_LS_ON) && ls_fall);
   assign dead     = (state == ST_DT_LS) || (state == ST_DT_HS);
   assign release_now = dead && (slew_done || (zcs_flag && flip) || expired);

   cmg_pol_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (cur_pos),
      .dout (pol_s)
   );

   cmg_zcs_detect det_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .pol_s     (pol_s),
      .fall_evt  (fall_evt),
      .fall_hs   (fall_hs),
      .light_load(light_load),
      .zcs_flag  (zcs_flag),
      .ss_req    (ss_req),
      .flip      (flip)
   );

   cmg_dt_timer #(.NORM_CYC(NORM_CYC), .ZCS_CYC(ZCS_CYC)) tmr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (fall_evt),
      .run     (dead && !release_now),
      .long_sel(zcs_flag),
      .expired (expired)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_HS_ON;
      end else begin
         unique case (state)
            ST_HS_ON: if (hs_fall)     state <= ST_DT_LS;
            ST_DT_LS: if (release_now) state <= ST_LS_ON;
            ST_LS_ON: if (ls_fall)     state <= ST_DT_HS;
            ST_DT_HS: if (release_now) state <= ST_HS_ON;
            default:                   state <= ST_HS_ON;
         endcase
      end
   end

   assign hs_en = (state == ST_HS_ON);
   assign ls_en = (state == ST_LS_ON);

   // R2
   excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_en && ls_en));
   // R2
   ls_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_en) |-> $past(!hs_en));
   // R2
   hs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en) |-> $past(!ls_en));
   // R8
   slew_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dead && slew_done) |=> !dead);
endmodule

// File: tb/cmg_deadtime_seq_tb_top.sv
module cmg_deadtime_seq_tb_top;
   localparam int CLK_HZ     = 100_000_000;
   localparam int NORM_DT_NS = 100;
   localparam int ZCS_DT_US  = 1;
   localparam int EXP_NORM   = (CLK_HZ / 1000) * NORM_DT_NS / 1_000_000;
   localparam int EXP_ZCS    = (CLK_HZ / 1_000_000) * ZCS_DT_US;
   localparam int EV_AT      = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hs_cmd = 1'b0, ls_cmd = 1'b0, cur_pos = 1'b0;
   logic slew_done = 1'b0, light_load = 1'b0;
   logic hs_en, ls_en, zcs_flag, ss_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   cmg_deadtime_seq #(.CLK_HZ(CLK_HZ), .NORM_DT_NS(NORM_DT_NS), .ZCS_DT_US(ZCS_DT_US)) dut_i (
      .clk(clk), .rst_n(rst_n), .hs_cmd(hs_cmd), .ls_cmd(ls_cmd), .cur_pos(cur_pos),
      .slew_done(slew_done), .light_load(light_load),
      .hs_en(hs_en), .ls_en(ls_en), .zcs_flag(zcs_flag), .ss_req(ss_req)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // one turn-off on the permitted side; ev: 0 none, 1 slew-done, 2 polarity flip
   task automatic run_case(input bit side_hs, input bit pol, input bit ll, input int ev);
      int k;
      bit exp_zcs;
      int exp_len;
      exp_zcs = !ll && (side_hs ? !pol : pol);
      exp_len = (ev == 1) ? EV_AT :
                (ev == 2 && exp_zcs) ? EV_AT + 2 :
                (exp_zcs ? EXP_ZCS : EXP_NORM);
      cur_pos = pol;
      light_load = ll;
      repeat (4) @(negedge clk);
      if (side_hs) hs_cmd = 1'b1; else ls_cmd = 1'b1;
      repeat (2) @(negedge clk);
      hs_cmd = 1'b0;
      ls_cmd = 1'b0;
      @(negedge clk);
      light_load = 1'b0;
      chk(side_hs ? "R3" : "R4", "zcs_flag after turn-off", zcs_flag, exp_zcs);
      chk(ll ? "R5" : "R7", "ss_req pulse", ss_req, exp_zcs);
      chk("R2", "both off in dead time", hs_en | ls_en, 0);
      k = 1;
      forever begin
         if (k == EV_AT && ev == 1) slew_done = 1'b1;
         if (k == EV_AT && ev == 2) cur_pos = !pol;
         @(negedge clk);
         slew_done = 1'b0;
         if (k == 1) chk("R7", "ss_req cleared", ss_req, 0);
         if (hs_en | ls_en) break;
         k++;
         if (k > 4 * EXP_ZCS) break;
      end
      chk(ev == 1 ? "R8" : (ev == 2 ? "R9" : "R10"), "dead interval length", k, exp_len);
      chk("R2", "opposite gate permitted", {hs_en, ls_en}, side_hs ? 2'b01 : 2'b10);
      chk("R6", "zcs_flag held", zcs_flag, exp_zcs);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset permissions", {hs_en, ls_en}, 2'b10);
      chk("R1", "reset flags", {zcs_flag, ss_req}, 2'b00);
      // non-permitted gate command is ignored
      ls_cmd = 1'b1;
      repeat (2) @(negedge clk);
      ls_cmd = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2", "ignored low-side pulse", {hs_en, ls_en, zcs_flag, ss_req}, 4'b1000);
      for (int ev = 0; ev < 3; ev++)
         for (int ll = 0; ll < 2; ll++)
            for (int pol = 0; pol < 2; pol++) begin
               run_case(1'b1, pol[0], ll[0], ev);
               run_case(1'b0, pol[0], ll[0], ev);
            end
      // high-side pulse while low-side permitted is ignored
      run_case(1'b1, 1'b0, 1'b0, 1);
      hs_cmd = 1'b1;
      repeat (2) @(negedge clk);
      hs_cmd = 1'b0;
      repeat (4) @(negedge clk);
      chk("R2", "ignored high-side pulse", {hs_en, ls_en, zcs_flag}, 3'b011);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150_000) @(negedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule